// File: doc/BRIEF.md
# Link Fault Journal Classifier

This block is the per-router fault bookkeeper of a mesh router with four link directions. It watches two event streams: the outcome of every packet transfer to a neighbour (acknowledged or refused), and the error-correction verdict on a packet that was sent back into the router's own input after repeated refusals. From these events it tells a passing glitch apart from a lasting fault. It also decides whether a lasting fault sits in an input block, an output block or the wire between two routers.

Each direction owns a short history of outcomes for its input side and a second one for its output side, plus a refusal counter for the packet currently held at that output. Three refusals in a row for one held packet raise a loopback request. If the looped packet then arrives clean, the link wire is marked permanently broken. If it arrives damaged, both histories involved record a failure. A history that fills with failures marks that side permanently faulty. An input fault is isolated locally, through that port's unavailable flag and the two corner flags next to it. A wire or output fault raises a one-shot request to tell the neighbour which of its ports to disable. The packet generator injects that notice in the input port of the faulty direction, so the notice never leaves through the broken link.

Top module: `link_fault_journal`

## Requirements
- R1: After reset every history is cleared, the counters are zero and every output is low: `loopback_valid`, `notify_valid`, `out_perm`, `bus_perm`, `in_unavail` and `diag_unavail`.
- R2: An acknowledged transfer (`tx_valid` with `tx_ack`=1) shifts a 0 into the input history of `tx_in_dir` and into the output history of `tx_out_dir`. It also clears the refusal count of `tx_out_dir`. Directions are encoded north=0, east=1, south=2, west=3.
- R3: The third refusal in a row (`tx_valid` with `tx_ack`=0) on one output direction raises `loopback_valid` for one cycle on the next clock edge, with `loopback_dir` naming that direction. The count then starts over, so a fourth refusal raises nothing.
- R4: Refusal counts are kept per output direction. Refusals on one direction neither add to nor clear the count of another.
- R5: A loopback verdict with no error (`lb_valid`, `lb_ecc_bad`=0) sets `bus_perm[lb_out_dir]` on the next edge and leaves both histories unchanged.
- R6: A loopback verdict with an uncorrectable error (`lb_ecc_bad`=1) shifts a 1 into the input history of `lb_in_dir` and into the output history of `lb_out_dir`.
- R7: Three 1s in a row in a history (depth `DEPTH`, default 3) set `in_unavail[d]` or `out_perm[d]` for that direction on the same edge as the third 1. The flag then stays set until reset.
- R8: `diag_unavail[k]` marks the corner between direction k and direction (k+1) mod 4. An input fault in direction d sets corners d and (d+3) mod 4.
- R9: Each direction whose `bus_perm` or `out_perm` becomes set produces exactly one `notify_valid` cycle, with `notify_dir` = d and `notify_port` = d XOR 2 (the neighbour's facing port). Another fault on a direction already notified raises no further notice.
- R10: When an acknowledgement and a damaged loopback verdict target the same history in one cycle, the 0 is shifted in first and the 1 second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A transfer outcome is presented |
| tx_ack | input | 1 | 1 = acknowledged, 0 = refused |
| tx_in_dir | input | 2 | Direction through which the packet entered |
| tx_out_dir | input | 2 | Direction through which the packet left |
| lb_valid | input | 1 | A loopback error-check verdict is presented |
| lb_ecc_bad | input | 1 | 1 = uncorrectable error in the looped packet |
| lb_in_dir | input | 2 | Entry direction of the looped packet |
| lb_out_dir | input | 2 | Output direction that looped the packet |
| loopback_valid | output | 1 | One-cycle loopback request |
| loopback_dir | output | 2 | Output direction to loop back |
| out_perm | output | 4 | Permanent output-block fault per direction |
| bus_perm | output | 4 | Permanent link-wire fault per direction |
| in_unavail | output | 4 | Input port unavailable (permanent input fault) |
| diag_unavail | output | 4 | Corner availability flags, bit k between directions k and k+1 |
| notify_valid | output | 1 | Request for a one-flit notice to a neighbour |
| notify_dir | output | 2 | Faulty direction, also the injection port |
| notify_port | output | 2 | Port the neighbour must disable |

## Verification
Refusal runs are interleaved across two directions and broken by an acknowledgement. This separates per-direction counting from a shared counter, and shows whether an acknowledgement resets the count. Damaged loopback verdicts are mixed with acknowledgements on the same histories. A "1,1,0,1" pattern must not declare a fault, while "1,1,1" must, which tells consecutive counting apart from counting in total. A clean loopback verdict checks that the wire classification bypasses the histories. Same-cycle acknowledgement and damaged verdict on one history show whether the shift order is kept, and the notice scoreboard shows that each faulty direction is reported once with the facing port.

// File: rtl/ljc_pkg.sv
package ljc_pkg;
  localparam int NDIR = 4;
  localparam int DIRW = 2;
  typedef logic [DIRW-1:0] dir_t;

  localparam dir_t DIR_N = 2'd0;
  localparam dir_t DIR_E = 2'd1;
  localparam dir_t DIR_S = 2'd2;
  localparam dir_t DIR_W = 2'd3;

  function automatic dir_t facing(input dir_t d);
    return d ^ 2'd2;
  endfunction
endpackage

// File: rtl/ljc_history.sv
module ljc_history #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_hit,
  input  logic first_bit,
  input  logic second_hit,
  input  logic second_bit,
  output logic perm
);
  logic [DEPTH-1:0] hist_q, hist_mid, hist_d;
  logic             perm_q, perm_d;
  logic             hist_en;

  always_comb begin
    hist_mid = first_hit  ? {hist_q[DEPTH-2:0], first_bit}    : hist_q;
    hist_d   = second_hit ? {hist_mid[DEPTH-2:0], second_bit} : hist_mid;
    hist_en  = first_hit | second_hit;
    perm_d   = perm_q | (&hist_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      perm_q <= 1'b0;
    end else begin
      if (hist_en) hist_q <= hist_d;
      perm_q <= perm_d;
    end
  end

  assign perm = perm_q;

  p_perm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  p_full_history_declares_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&hist_q) |-> perm_q);
endmodule

// File: rtl/ljc_refusal_ctr.sv
module ljc_refusal_ctr #(
  parameter int STRIKES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  output logic loop_req
);
  localparam int CW = $clog2(STRIKES + 1);
  localparam logic [CW-1:0] LAST = CW'(STRIKES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          loop_q, loop_d;

  always_comb begin
    cnt_d  = cnt_q;
    loop_d = 1'b0;
    if (hit) begin
      if (ack) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        cnt_d  = '0;
        loop_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      loop_q <= 1'b0;
    end else begin
      if (hit) cnt_q <= cnt_d;
      loop_q <= loop_d;
    end
  end

  assign loop_req = loop_q;

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_loop_after_strikes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> $past(hit && !ack && cnt_q == LAST));
  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ack) |=> (cnt_q == '0 && !loop_q));
endmodule

// File: rtl/ljc_notify_arb.sv
module ljc_notify_arb
  import ljc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIR-1:0] fault,
  output logic            notify_valid,
  output dir_t            notify_dir,
  output dir_t            notify_port
);
  logic [NDIR-1:0] done_q, done_d, pending, grant;

  always_comb begin
    pending    = fault & ~done_q;
    grant      = '0;
    notify_dir = DIR_N;
    for (int i = NDIR - 1; i >= 0; i--) begin
      if (pending[i]) begin
        grant      = '0;
        grant[i]   = 1'b1;
        notify_dir = dir_t'(i);
      end
    end
    notify_valid = |pending;
    notify_port  = facing(notify_dir);
    done_d       = done_q | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= done_d;
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_once_per_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |=> !done_q[$past(notify_dir)] ? 1'b0 : 1'b1);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != '0) |=> ((done_q & $past(done_q)) == $past(done_q)));
endmodule

// File: rtl/link_fault_journal.sv
module link_fault_journal
  import ljc_pkg::*;
#(
  parameter int DEPTH   = 3,
  parameter int STRIKES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic       tx_ack,
  input  logic [1:0] tx_in_dir,
  input  logic [1:0] tx_out_dir,
  input  logic       lb_valid,
  input  logic       lb_ecc_bad,
  input  logic [1:0] lb_in_dir,
  input  logic [1:0] lb_out_dir,
  output logic       loopback_valid,
  output logic [1:0] loopback_dir,
  output logic [3:0] out_perm,
  output logic [3:0] bus_perm,
  output logic [3:0] in_unavail,
  output logic [3:0] diag_unavail,
  output logic       notify_valid,
  output logic [1:0] notify_dir,
  output logic [1:0] notify_port
);
  logic            rst_meta_q, rst_sync_q;
  logic [NDIR-1:0] in_fault, out_fault, loop_vec;
  logic [NDIR-1:0] bus_q, bus_d;
  logic            ack_ev, nack_ev, lb_bad_ev, lb_good_ev;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    ack_ev     = tx_valid & tx_ack;
    nack_ev    = tx_valid & ~tx_ack;
    lb_bad_ev  = lb_valid & lb_ecc_bad;
    lb_good_ev = lb_valid & ~lb_ecc_bad;
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ljc_history #(.DEPTH(DEPTH)) u_in_hist (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .first_hit  (ack_ev && tx_in_dir == dir_t'(d)),
      .first_bit  (1'b0),
      .second_hit (lb_bad_ev && lb_in_dir == dir_t'(d)),
      .second_bit (1'b1),
      .perm       (in_fault[d])
    );

    ljc_history #(.DEPTH(DEPTH)) u_out_hist (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .first_hit  (ack_ev && tx_out_dir == dir_t'(d)),
      .first_bit  (1'b0),
      .second_hit (lb_bad_ev && lb_out_dir == dir_t'(d)),
      .second_bit (1'b1),
      .perm       (out_fault[d])
    );

    ljc_refusal_ctr #(.STRIKES(STRIKES)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .hit      ((ack_ev || nack_ev) && tx_out_dir == dir_t'(d)),
      .ack      (tx_ack),
      .loop_req (loop_vec[d])
    );

    assign bus_d[d]        = bus_q[d] | (lb_good_ev && lb_out_dir == dir_t'(d));
    assign diag_unavail[d] = in_fault[d] | in_fault[(d + 1) % NDIR];

    p_corner_flags_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
      in_unavail[d] |-> (diag_unavail[d] && diag_unavail[(d + NDIR - 1) % NDIR]));
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) bus_q <= '0;
    else             bus_q <= bus_d;
  end

  always_comb begin
    loopback_valid = |loop_vec;
    loopback_dir   = DIR_N;
    for (int i = 0; i < NDIR; i++) begin
      if (loop_vec[i]) loopback_dir = dir_t'(i);
    end
  end

  assign out_perm   = out_fault;
  assign bus_perm   = bus_q;
  assign in_unavail = in_fault;

  ljc_notify_arb u_notify (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .fault        (bus_q | out_fault),
    .notify_valid (notify_valid),
    .notify_dir   (notify_dir),
    .notify_port  (notify_port)
  );

  p_loop_onehot_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(loop_vec));
  p_bus_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_q != '0) |=> ((bus_q & $past(bus_q)) == $past(bus_q)));
  p_bus_from_clean_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(bus_q[0]) |-> $past(lb_good_ev && lb_out_dir == DIR_N));
endmodule

// File: tb/link_fault_journal_tb.sv
module link_fault_journal_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, tx_ack = 1'b0;
  logic [1:0] tx_in_dir = '0, tx_out_dir = '0;
  logic       lb_valid = 1'b0, lb_ecc_bad = 1'b0;
  logic [1:0] lb_in_dir = '0, lb_out_dir = '0;
  logic       loopback_valid, notify_valid;
  logic [1:0] loopback_dir, notify_dir, notify_port;
  logic [3:0] out_perm, bus_perm, in_unavail, diag_unavail;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic [3:0] exp_q[$];

  always #4 clk = ~clk;

  link_fault_journal u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ack(tx_ack), .tx_in_dir(tx_in_dir), .tx_out_dir(tx_out_dir),
    .lb_valid(lb_valid), .lb_ecc_bad(lb_ecc_bad), .lb_in_dir(lb_in_dir), .lb_out_dir(lb_out_dir),
    .loopback_valid(loopback_valid), .loopback_dir(loopback_dir),
    .out_perm(out_perm), .bus_perm(bus_perm), .in_unavail(in_unavail), .diag_unavail(diag_unavail),
    .notify_valid(notify_valid), .notify_dir(notify_dir), .notify_port(notify_port)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one event cycle; outputs are sampled at the following falling edge
  task automatic ev(input logic txv, input logic ack, input logic [1:0] ti, input logic [1:0] to,
                    input logic lbv, input logic bad, input logic [1:0] li, input logic [1:0] lo);
    tx_valid = txv; tx_ack = ack; tx_in_dir = ti; tx_out_dir = to;
    lb_valid = lbv; lb_ecc_bad = bad; lb_in_dir = li; lb_out_dir = lo;
    @(negedge clk);
    tx_valid = 1'b0; lb_valid = 1'b0;
  endtask

  task automatic tx(input logic ack, input logic [1:0] ti, input logic [1:0] to);
    ev(1'b1, ack, ti, to, 1'b0, 1'b0, 2'd0, 2'd0);
  endtask

  task automatic lb(input logic bad, input logic [1:0] li, input logic [1:0] lo);
    ev(1'b0, 1'b0, 2'd0, 2'd0, 1'b1, bad, li, lo);
  endtask

  // scoreboard monitor for neighbour notices
  always @(negedge clk) begin
    if (rst_n && notify_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R9: unexpected notice actual dir %0d port %0d expected none",
                 notify_dir, notify_port);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if ({notify_dir, notify_port} !== e) begin
          n_errors++;
          $display("FAIL R9: notice actual %0h expected %0h", {notify_dir, notify_port}, e);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 loopback", {7'd0, loopback_valid}, 8'd0);
    chk("R1 notify", {7'd0, notify_valid}, 8'd0);
    chk("R1 flags", {out_perm, bus_perm}, 8'd0);
    chk("R1 unavail", {in_unavail, diag_unavail}, 8'd0);

    // R3/R4 interleaved refusals
    tx(1'b0, 2'd0, 2'd1);
    tx(1'b0, 2'd0, 2'd1);
    tx(1'b0, 2'd0, 2'd2);
    chk("R4 no loop from other dir", {7'd0, loopback_valid}, 8'd0);
    tx(1'b0, 2'd0, 2'd1);
    chk("R3 loop on third refusal", {5'd0, loopback_valid, loopback_dir}, {5'd0, 1'b1, 2'd1});
    tx(1'b0, 2'd0, 2'd2);
    chk("R4 second refusal dir2", {7'd0, loopback_valid}, 8'd0);
    tx(1'b0, 2'd0, 2'd2);
    chk("R4 dir2 own count", {5'd0, loopback_valid, loopback_dir}, {5'd0, 1'b1, 2'd2});
    tx(1'b0, 2'd0, 2'd1);
    chk("R3 count restarted", {7'd0, loopback_valid}, 8'd0);
    // R2 acknowledgement clears count
    tx(1'b0, 2'd0, 2'd0);
    tx(1'b0, 2'd0, 2'd0);
    tx(1'b1, 2'd0, 2'd0);
    tx(1'b0, 2'd0, 2'd0);
    chk("R2 ack cleared count", {7'd0, loopback_valid}, 8'd0);

    // R5 clean loopback marks the wire
    exp_q.push_back({2'd3, 2'd1});
    lb(1'b0, 2'd0, 2'd3);
    chk("R5 bus flag", {4'd0, bus_perm}, 8'b1000);
    chk("R5 histories untouched", {out_perm, in_unavail}, 8'd0);

    // R6/R7 damaged loopbacks, broken run on in0
    lb(1'b1, 2'd0, 2'd1);
    lb(1'b1, 2'd0, 2'd1);
    tx(1'b1, 2'd0, 2'd2);
    exp_q.push_back({2'd1, 2'd3});
    lb(1'b1, 2'd0, 2'd1);
    chk("R6 out1 three ones", {4'd0, out_perm}, 8'b0010);
    chk("R2 ack broke in0 run", {4'd0, in_unavail}, 8'd0);
    lb(1'b1, 2'd0, 2'd2);
    chk("R7 in0 two ones", {4'd0, in_unavail}, 8'd0);
    lb(1'b1, 2'd0, 2'd2);
    chk("R7 in0 declared", {4'd0, in_unavail}, 8'b0001);
    chk("R8 corners for north", {4'd0, diag_unavail}, 8'b1001);
    chk("R2 out2 has ack in run", {4'd0, out_perm}, 8'b0010);

    // R10 same-cycle ack and damaged verdict on in2
    lb(1'b1, 2'd2, 2'd0);
    lb(1'b1, 2'd2, 2'd0);
    exp_q.push_back({2'd0, 2'd2});
    ev(1'b1, 1'b1, 2'd2, 2'd3, 1'b1, 1'b1, 2'd2, 2'd0);
    chk("R10 ack shifted before one", {4'd0, in_unavail}, 8'b0001);
    chk("R6 out0 declared", {4'd0, out_perm}, 8'b0011);
    lb(1'b1, 2'd2, 2'd0);
    chk("R10 run still short", {4'd0, in_unavail}, 8'b0001);
    lb(1'b1, 2'd2, 2'd0);
    chk("R7 in2 declared", {4'd0, in_unavail}, 8'b0101);
    chk("R8 corners all", {4'd0, diag_unavail}, 8'b1111);

    // R7 stickiness, R9 no repeat notice
    tx(1'b1, 2'd2, 2'd1);
    tx(1'b1, 2'd0, 2'd1);
    lb(1'b0, 2'd1, 2'd3);
    chk("R7 flags sticky", {in_unavail, out_perm}, {4'b0101, 4'b0011});
    chk("R5 bus unchanged", {4'd0, bus_perm}, 8'b1000);
    repeat (4) @(negedge clk);
    chk("R9 all notices seen", 8'(exp_q.size()), 8'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule